// File: doc/BRIEF.md
# Write-Unlock Sequence Guard

This block sits in front of a byte-wide page-write controller and decides, write by write, whether captured bus writes may be stored. It powers up with protection armed. Before any data can be stored, three key writes must arrive in order, each pairing a fixed address with a fixed data byte. The key bytes themselves are never stored. Once the third key write is seen, protection opens and later writes are passed to the page controller as commits, as long as they stay on one page. The key addresses carry no special meaning after unlock and can be written like any other location.

A write that arrives while protection is armed and does not continue the key is not dropped silently. The guard raises a one-cycle request for a dummy busy cycle. The page controller then runs its normal write timer so that the device looks busy, but it commits nothing. Key writes must be spaced no further apart than the byte-load window. A longer gap abandons the sequence. The controller reports the end of every write cycle, real or dummy, and that report re-arms protection.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset, prot_o is 1 and commit_o and dummy_o are 0.
- R2: Writes of (0x1555, 0xAA), then (0x0AAA, 0x55), then (0x1555, 0xA0) open protection: prot_o is 0 in the cycle after the third write. None of the three writes raises commit_o or dummy_o.
- R3: While protection is open, each write raises commit_o for exactly the one cycle after the write. This includes writes to the key addresses.
- R4: While the guard waits for the first key write, any write that is not the first key write raises dummy_o for one cycle and no commit, and prot_o stays 1.
- R5: If the second or third write of the sequence does not match its key entry, dummy_o is raised. The next sequence must then start again from the first key write.
- R6: A key write counts only if it arrives no more than WIN_CYC clock cycles after the previous key write. A later write is judged as if it were the first write of a new sequence.
- R7: After a dummy request, writes raise neither commit_o nor dummy_o until cycle_done_i is seen. After that, the guard waits for the first key write.
- R8: cycle_done_i while protection is open sets prot_o to 1 in the following cycle. A later write without the key then raises dummy_o.
- R9: While protection is open, the first committed write fixes the page (address bits 12:6). A later write to a different page raises no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_evt_i | input | 1 | One-cycle strobe for a captured bus write |
| wr_addr_i | input | 13 | Address of the captured write |
| wr_data_i | input | 8 | Data of the captured write |
| cycle_done_i | input | 1 | One-cycle strobe: the write cycle, real or dummy, has ended |
| commit_o | output | 1 | One-cycle pulse: store the write just seen |
| dummy_o | output | 1 | One-cycle pulse: start a busy cycle that stores nothing |
| prot_o | output | 1 | 1 while protection is armed |

## Verification
The assertions assume that wr_evt_i and cycle_done_i are never high in the same cycle. They also assume that cycle_done_i comes only after a write cycle has really started, either an unlocked load or a dummy request. The directed tasks never drive cycle_done_i in a cycle that carries a write, and they pulse cycle_done_i only after an unlock or a dummy request.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    ST_STEP0 = 3'd0,
    ST_STEP1 = 3'd1,
    ST_STEP2 = 3'd2,
    ST_OPEN  = 3'd3,
    ST_HOLD  = 3'd4
  } wp_state_e;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int KEY_N  = 3,
  parameter logic [KEY_N*ADDR_W-1:0] KEY_ADDRS = '0,
  parameter logic [KEY_N*DATA_W-1:0] KEY_DATAS = '0,
  localparam int STEP_W = $clog2(KEY_N + 1)
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);
  logic [KEY_N-1:0] hit_vec;

  // Entry 0 sits in the low bits of the key vectors.
  for (genvar i = 0; i < KEY_N; i++) begin : g_key
    assign hit_vec[i] = (addr_i == KEY_ADDRS[i*ADDR_W +: ADDR_W]) &&
                        (data_i == KEY_DATAS[i*DATA_W +: DATA_W]);
  end

  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < KEY_N; i++) begin
      if (step_i == STEP_W'(i)) hit_o = hit_vec[i];
    end
  end
endmodule

// File: rtl/wp_window_timer.sv
module wp_window_timer #(
  parameter int WIN_CYC = 32,
  localparam int CNT_W = $clog2(WIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clear_i || (run_i && !expired_o);

  always_comb begin
    if (clear_i || !run_i) cnt_d = '0;
    else                   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q >= CNT_W'(WIN_CYC));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WIN_CYC));
endmodule

// File: rtl/wp_page_guard.sv
module wp_page_guard #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              match_o
);
  logic              valid_q, valid_d;
  logic [PAGE_W-1:0] page_q;
  logic              page_en;

  assign match_o = !valid_q || (page_i == page_q);
  assign page_en = wr_i && !valid_q && !clr_i;

  always_comb begin
    valid_d = valid_q;
    if (clr_i)        valid_d = 1'b0;
    else if (page_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (page_en) page_q <= page_i;
    end
  end
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int PAGE_LSB = 6,
  parameter int WIN_CYC  = 32,
  localparam int PAGE_W  = ADDR_W - PAGE_LSB,
  localparam int KEY_N   = 3,
  localparam int STEP_W  = $clog2(KEY_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cycle_done_i,
  output logic              commit_o,
  output logic              dummy_o,
  output logic              prot_o
);
  localparam logic [KEY_N*ADDR_W-1:0] KEY_A =
    {ADDR_W'('h1555), ADDR_W'('h0AAA), ADDR_W'('h1555)};
  localparam logic [KEY_N*DATA_W-1:0] KEY_D =
    {DATA_W'('hA0), DATA_W'('h55), DATA_W'('hAA)};

  wp_state_e         state_q, state_d;
  logic              commit_d, dummy_d, prot_d;
  logic              in_key, tmr_expired, key_hit, page_ok, pg_wr;
  logic [STEP_W-1:0] eff_step;

  assign in_key   = (state_q == ST_STEP1) || (state_q == ST_STEP2);
  assign eff_step = (in_key && !tmr_expired) ? STEP_W'(state_q) : '0;

  wp_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_N(KEY_N),
    .KEY_ADDRS(KEY_A), .KEY_DATAS(KEY_D)
  ) u_key (
    .step_i(eff_step), .addr_i(wr_addr_i), .data_i(wr_data_i), .hit_o(key_hit)
  );

  wp_window_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(in_key), .clear_i(wr_evt_i),
    .expired_o(tmr_expired)
  );

  assign pg_wr = (state_q == ST_OPEN) && wr_evt_i && !cycle_done_i;

  wp_page_guard #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .clr_i(state_q != ST_OPEN), .wr_i(pg_wr),
    .page_i(wr_addr_i[ADDR_W-1:PAGE_LSB]), .match_o(page_ok)
  );

  always_comb begin
    state_d  = state_q;
    commit_d = 1'b0;
    dummy_d  = 1'b0;
    unique case (state_q)
      ST_STEP0, ST_STEP1, ST_STEP2: begin
        if (wr_evt_i) begin
          if (!key_hit) begin
            dummy_d = 1'b1;
            state_d = ST_HOLD;
          end else if (eff_step == STEP_W'(KEY_N - 1)) begin
            state_d = ST_OPEN;
          end else begin
            state_d = wp_state_e'(3'(eff_step) + 3'd1);
          end
        end else if (in_key && tmr_expired) begin
          state_d = ST_STEP0;
        end
      end
      ST_OPEN: begin
        if (cycle_done_i)               state_d  = ST_STEP0;
        else if (wr_evt_i && page_ok)   commit_d = 1'b1;
      end
      ST_HOLD: begin
        if (cycle_done_i) state_d = ST_STEP0;
      end
      default: state_d = ST_STEP0;
    endcase
    prot_d = (state_d != ST_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_STEP0;
      commit_o <= 1'b0;
      dummy_o  <= 1'b0;
      prot_o   <= 1'b1;
    end else begin
      state_q  <= state_d;
      commit_o <= commit_d;
      dummy_o  <= dummy_d;
      prot_o   <= prot_d;
    end
  end

  // R3
  commit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(!prot_o) && $past(wr_evt_i)));
  // R4
  dummy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_o |-> ($past(wr_evt_i) && prot_o && !commit_o));
  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_o) |-> $past(wr_evt_i));
  // R8
  rearm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_o) |-> $past(cycle_done_i));
  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !cycle_done_i) |=> (!commit_o && !dummy_o));
endmodule

// File: tb/wp_seq_guard_bench.sv
`timescale 1ns/1ps
module wp_seq_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_evt;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic        cyc_done;
  logic        commit, dummy, prot;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  wp_seq_guard u_wp_seq_guard (
    .clk(clk), .rst_n(rst_n), .wr_evt_i(wr_evt), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cycle_done_i(cyc_done),
    .commit_o(commit), .dummy_o(dummy), .prot_o(prot)
  );

  task automatic chk(input string tag, input logic c, input logic d, input logic p);
    n_chk++;
    if (commit !== c || dummy !== d || prot !== p) begin
      n_err++;
      $display("FAIL %s: commit/dummy/prot got %b%b%b exp %b%b%b",
               tag, commit, dummy, prot, c, d, p);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_evt = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_evt = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic key_all();
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hA0);
  endtask

  task automatic t_reset();
    chk("R1 reset", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_unlock_commit();
    wr(13'h1555, 8'hAA); chk("R2 key1", 0, 0, 1);
    wr(13'h0AAA, 8'h55); chk("R2 key2", 0, 0, 1);
    wr(13'h1555, 8'hA0); chk("R2 key3", 0, 0, 0);
    wr(13'h1540, 8'h11); chk("R3 commit", 1, 0, 0);
    idle(1);             chk("R3 one cycle", 0, 0, 0);
    wr(13'h1555, 8'h22); chk("R3 key addr stored", 1, 0, 0);
    wr(13'h0040, 8'h33); chk("R9 other page", 0, 0, 0);
    wr(13'h157F, 8'h44); chk("R9 same page", 1, 0, 0);
    done_pulse();        chk("R8 rearm", 0, 0, 1);
    wr(13'h1540, 8'h55); chk("R8 unkeyed dummy", 0, 1, 1);
    done_pulse();
  endtask

  task automatic t_unkeyed();
    wr(13'h0100, 8'h5A); chk("R4 unkeyed", 0, 1, 1);
    wr(13'h1555, 8'hAA); chk("R7 hold ignores", 0, 0, 1);
    wr(13'h0AAA, 8'h55); chk("R7 hold ignores 2", 0, 0, 1);
    done_pulse();        chk("R7 done", 0, 0, 1);
    key_all();           chk("R7 fresh key", 0, 0, 0);
    done_pulse();
  endtask

  task automatic t_mid_mismatch();
    wr(13'h1555, 8'hAA); chk("R5 key1", 0, 0, 1);
    wr(13'h0AAA, 8'h54); chk("R5 bad key2", 0, 1, 1);
    done_pulse();
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hA1); chk("R5 bad key3", 0, 1, 1);
    done_pulse();
    wr(13'h0AAA, 8'h55); chk("R5 restart at step0", 0, 1, 1);
    done_pulse();
  endtask

  task automatic t_window();
    // gap between write strobes = 2 + idle count
    wr(13'h1555, 8'hAA); idle(30);
    wr(13'h0AAA, 8'h55); idle(30);
    wr(13'h1555, 8'hA0); chk("R6 gap at limit", 0, 0, 0);
    done_pulse();
    wr(13'h1555, 8'hAA); idle(31);
    wr(13'h0AAA, 8'h55); chk("R6 late write", 0, 1, 1);
    done_pulse();
    wr(13'h1555, 8'hAA); idle(40);
    key_all();           chk("R6 abandoned then fresh", 0, 0, 0);
    done_pulse();
  endtask

  initial begin
    rst_n = 1'b0; wr_evt = 1'b0; wr_addr = '0; wr_data = '0; cyc_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock_commit();
    t_unkeyed();
    t_mid_mismatch();
    t_window();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule